// File: doc/BRIEF.md
# Split-Counter Stream DMA Channel

This block is one channel of a stream mover. Words enter from a source port with a valid/ready handshake, wait in a small staging buffer, and leave through a sink port with the same handshake. The source side and the sink side each keep their own count of words still to go. Software sets a transfer length and an enable bit, and can read both counts at any time. The sink count is the one that shows what has actually reached the destination, so it is the residue that should be reported. The source count can run ahead of it by the number of words held in the buffer.

The sink side only starts a burst once a full burst of words is held. A short tail that never fills a burst therefore stays in the buffer, and the sink count stays where it is. Dropping the enable bit moves the channel into a flush. The flush writes out whatever is held, including a short tail, then leaves the channel idle. A new transfer needs a fresh 0-to-1 edge on the enable bit while the channel is idle.

The controller has four states. ST_IDLE goes to ST_RUN on a rising enable, which also loads both counts. ST_RUN goes to ST_FLUSH when enable falls, or to ST_DONE when the sink count reaches zero. ST_FLUSH goes to ST_IDLE once the buffer is empty and no burst is open. ST_DONE goes to ST_IDLE when enable falls.

Top module: `dma_split_chan`

## Requirements
- R1: After reset the channel is idle (`chan_idle`=1, `chan_done`=0). `src_ready` and `snk_valid` are 0 and both counts read 0.
- R2: A 0-to-1 change of `cfg_en` seen while idle loads `rd_remain` and `wr_remain` with `cfg_count` on that clock edge and clears `chan_idle`.
- R3: `rd_remain` drops by exactly one for each accepted source word. `src_ready` is 0 whenever `rd_remain` is 0, so the count never wraps.
- R4: `wr_remain` drops by exactly one for each sink handshake. Sink words come out in the order they were accepted.
- R5: While enabled, the sink starts a burst only when at least BURST words are held. A started burst keeps `snk_valid` high for exactly BURST handshakes. With fewer than BURST words held and enable high, `snk_valid` stays 0 and `wr_remain` does not change.
- R6: At all times, `wr_remain` minus `rd_remain` equals the number of words held in the buffer.
- R7: With DEPTH words held, `src_ready` is 0 and the source stalls.
- R8: Clearing `cfg_en` during a transfer stops source intake and writes every held word, a short tail included, to the sink. `wr_remain` drops for each of those words.
- R9: When the flush completes, `chan_idle` becomes 1. While idle, `src_ready` stays 0 and `rd_remain` does not change, until a new rising enable.
- R10: When `wr_remain` reaches 0, `chan_done` becomes 1 and `src_ready` is 0. `chan_done` stays set until `cfg_en` is cleared, and the channel then returns to idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_en | input | 1 | Channel enable; a rising edge starts a transfer, a falling edge flushes |
| cfg_count | input | CNT_W | Transfer length in words, captured on the enable rising edge |
| src_valid | input | 1 | Source offers a word |
| src_data | input | DATA_W | Source word |
| src_ready | output | 1 | Channel accepts the source word |
| snk_valid | output | 1 | Channel offers a word to the sink |
| snk_data | output | DATA_W | Sink word |
| snk_ready | input | 1 | Sink accepts the word |
| rd_remain | output | CNT_W | Words still to be taken from the source |
| wr_remain | output | CNT_W | Words still to be delivered to the sink (residue) |
| chan_idle | output | 1 | Channel idle |
| chan_done | output | 1 | Transfer complete |

## Verification
The bench leaves a short tail of fewer than a burst in the buffer with enable high. A design that drains partial bursts early would move `wr_remain` or raise `snk_valid` at that point. It then drops enable and checks that exactly the held words come out. A flush that dropped the tail would leave `wr_remain` too high, and one that kept reading the source would disturb `rd_remain` while idle. Sink backpressure fills the buffer to test the source stall, where an off-by-one full flag would overrun a slot. On every cycle the bench compares both counts and the sink data order with its own handshake tally. A design that decremented the wrong counter, or let the two counts drift apart, fails on the first cycle it happens.

// File: rtl/dsc_pkg.sv
package dsc_pkg;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_RUN   = 2'd1,
        ST_FLUSH = 2'd2,
        ST_DONE  = 2'd3
    } chan_state_t;

endpackage

// File: rtl/stage_fifo.sv
module stage_fifo #(
    parameter int DATA_W = 16,
    parameter int DEPTH  = 8,
    localparam int AW    = (DEPTH > 1) ? $clog2(DEPTH) : 1,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push,
    input  logic [DATA_W-1:0] push_data,
    input  logic              pop,
    output logic [DATA_W-1:0] head_data,
    output logic [CW-1:0]     fill,
    output logic              full,
    output logic              empty
);

    localparam logic [AW-1:0] LAST_IDX = AW'(DEPTH - 1);
    localparam logic [CW-1:0] DEPTH_C  = CW'(DEPTH);

    logic [DATA_W-1:0] store [DEPTH];
    logic [AW-1:0]     wr_ptr;
    logic [AW-1:0]     rd_ptr;

    always_ff @(posedge clk) begin
        if (push) begin
            store[wr_ptr] <= push_data;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wr_ptr <= '0;
            rd_ptr <= '0;
            fill   <= '0;
        end else begin
            if (push) begin
                wr_ptr <= (wr_ptr == LAST_IDX) ? '0 : wr_ptr + 1'b1;
            end
            if (pop) begin
                rd_ptr <= (rd_ptr == LAST_IDX) ? '0 : rd_ptr + 1'b1;
            end
            unique case ({push, pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end

    always_comb begin
        head_data = store[rd_ptr];
        full      = (fill == DEPTH_C);
        empty     = (fill == '0);
    end

    AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        push |-> (fill < DEPTH_C)); // R7
    AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
        pop |-> (fill != '0)); // R4

endmodule

// File: rtl/xfer_counter.sv
module xfer_counter #(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic [CNT_W-1:0] load_val,
    input  logic             dec,
    output logic [CNT_W-1:0] value
);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            value <= '0;
        end else if (load) begin
            value <= load_val;
        end else if (dec) begin
            value <= value - 1'b1;
        end
    end

    AST_NO_WRAP: assert property (@(posedge clk) disable iff (!rst_n)
        (dec && !load) |-> (value != '0)); // R3

endmodule

// File: rtl/burst_drain.sv
module burst_drain #(
    parameter int DEPTH = 8,
    parameter int BURST = 4,
    localparam int CW   = $clog2(DEPTH + 1),
    localparam int BW   = $clog2(BURST + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          flush_mode,
    input  logic [CW-1:0] fill,
    input  logic          snk_ready,
    output logic          snk_valid,
    output logic          pop,
    output logic          busy
);

    localparam logic [CW-1:0] BURST_F = CW'(BURST);
    localparam logic [BW-1:0] BURST_B = BW'(BURST);

    logic [BW-1:0] beats_left;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            beats_left <= '0;
        end else if (beats_left == '0) begin
            if (fill >= BURST_F) begin
                beats_left <= BURST_B;
            end else if (flush_mode && (fill != '0)) begin
                beats_left <= BW'(fill);
            end
        end else if (pop) begin
            beats_left <= beats_left - 1'b1;
        end
    end

    always_comb begin
        busy      = (beats_left != '0);
        snk_valid = busy;
        pop       = snk_valid && snk_ready;
    end

    AST_BURST_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (snk_valid && !snk_ready) |=> snk_valid); // R5

endmodule

// File: rtl/chan_fsm.sv
module chan_fsm
    import dsc_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cfg_en,
    input  logic        wr_zero,
    input  logic        buf_empty,
    input  logic        burst_busy,
    output chan_state_t state,
    output logic        load,
    output logic        run,
    output logic        flush_mode,
    output logic        chan_idle,
    output logic        chan_done
);

    chan_state_t state_nx;
    logic        en_q;
    logic        en_rise;

    assign en_rise = cfg_en && !en_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            en_q  <= 1'b0;
        end else begin
            state <= state_nx;
            en_q  <= cfg_en;
        end
    end

    always_comb begin
        state_nx = state;
        load     = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (en_rise) begin
                    state_nx = ST_RUN;
                    load     = 1'b1;
                end
            end
            ST_RUN: begin
                if (!cfg_en) begin
                    state_nx = ST_FLUSH;
                end else if (wr_zero) begin
                    state_nx = ST_DONE;
                end
            end
            ST_FLUSH: begin
                if (buf_empty && !burst_busy) begin
                    state_nx = ST_IDLE;
                end
            end
            ST_DONE: begin
                if (!cfg_en) begin
                    state_nx = ST_IDLE;
                end
            end
            default: state_nx = ST_IDLE;
        endcase
    end

    always_comb begin
        run        = (state == ST_RUN);
        flush_mode = (state == ST_FLUSH);
        chan_idle  = (state == ST_IDLE);
        chan_done  = (state == ST_DONE);
    end

    AST_DONE_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> wr_zero); // R10
    AST_FLUSH_LEAVES_EMPTY: assert property (@(posedge clk) disable iff (!rst_n)
        ((state == ST_IDLE) && ($past(state) == ST_FLUSH)) |-> buf_empty); // R8

endmodule

// File: rtl/dma_split_chan.sv
module dma_split_chan
    import dsc_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16,
    parameter int BURST  = 4,
    parameter int DEPTH  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_en,
    input  logic [CNT_W-1:0]  cfg_count,
    input  logic              src_valid,
    input  logic [DATA_W-1:0] src_data,
    output logic              src_ready,
    output logic              snk_valid,
    output logic [DATA_W-1:0] snk_data,
    input  logic              snk_ready,
    output logic [CNT_W-1:0]  rd_remain,
    output logic [CNT_W-1:0]  wr_remain,
    output logic              chan_idle,
    output logic              chan_done
);

    localparam int CW = $clog2(DEPTH + 1);
    localparam logic [CW-1:0] BURST_F = CW'(BURST);

    chan_state_t   state;
    logic          load;
    logic          run;
    logic          flush_mode;
    logic          push;
    logic          pop;
    logic          buf_full;
    logic          buf_empty;
    logic          burst_busy;
    logic [CW-1:0] fill;

    always_comb begin
        src_ready = run && !buf_full && (rd_remain != '0);
        push      = src_valid && src_ready;
    end

    chan_fsm u_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .cfg_en     (cfg_en),
        .wr_zero    (wr_remain == '0),
        .buf_empty  (buf_empty),
        .burst_busy (burst_busy),
        .state      (state),
        .load       (load),
        .run        (run),
        .flush_mode (flush_mode),
        .chan_idle  (chan_idle),
        .chan_done  (chan_done)
    );

    stage_fifo #(
        .DATA_W (DATA_W),
        .DEPTH  (DEPTH)
    ) u_buf (
        .clk       (clk),
        .rst_n     (rst_n),
        .push      (push),
        .push_data (src_data),
        .pop       (pop),
        .head_data (snk_data),
        .fill      (fill),
        .full      (buf_full),
        .empty     (buf_empty)
    );

    burst_drain #(
        .DEPTH (DEPTH),
        .BURST (BURST)
    ) u_drain (
        .clk        (clk),
        .rst_n      (rst_n),
        .flush_mode (flush_mode),
        .fill       (fill),
        .snk_ready  (snk_ready),
        .snk_valid  (snk_valid),
        .pop        (pop),
        .busy       (burst_busy)
    );

    xfer_counter #(.CNT_W(CNT_W)) u_rd_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cfg_count),
        .dec      (push),
        .value    (rd_remain)
    );

    xfer_counter #(.CNT_W(CNT_W)) u_wr_cnt (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (load),
        .load_val (cfg_count),
        .dec      (pop),
        .value    (wr_remain)
    );

    AST_COUNT_GAP: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_remain - rd_remain) == CNT_W'(fill)); // R6
    AST_PARTIAL_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        (run && (fill < BURST_F) && !snk_valid) |=> !snk_valid); // R5
    AST_IDLE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        chan_idle |-> !push); // R9
    AST_DONE_NO_READ: assert property (@(posedge clk) disable iff (!rst_n)
        chan_done |-> !src_ready); // R10

endmodule

// File: tb/test_dma_split_chan.sv
module test_dma_split_chan;

    localparam int DATA_W = 16;
    localparam int CNT_W  = 16;
    localparam int BURST  = 4;
    localparam int DEPTH  = 8;

    logic              clk = 1'b0;
    logic              rst_n;
    logic              cfg_en;
    logic [CNT_W-1:0]  cfg_count;
    logic              src_valid;
    logic [DATA_W-1:0] src_data;
    logic              src_ready;
    logic              snk_valid;
    logic [DATA_W-1:0] snk_data;
    logic              snk_ready;
    logic [CNT_W-1:0]  rd_remain;
    logic [CNT_W-1:0]  wr_remain;
    logic              chan_idle;
    logic              chan_done;

    int checks = 0;
    int errors = 0;
    int pushed, popped, cnt, burst_hs;
    bit track, prev_valid;
    logic [DATA_W-1:0] next_word, pop_word;

    always #2 clk = ~clk;

    dma_split_chan #(
        .DATA_W (DATA_W),
        .CNT_W  (CNT_W),
        .BURST  (BURST),
        .DEPTH  (DEPTH)
    ) i_dma_split_chan (
        .clk       (clk),
        .rst_n     (rst_n),
        .cfg_en    (cfg_en),
        .cfg_count (cfg_count),
        .src_valid (src_valid),
        .src_data  (src_data),
        .src_ready (src_ready),
        .snk_valid (snk_valid),
        .snk_data  (snk_data),
        .snk_ready (snk_ready),
        .rd_remain (rd_remain),
        .wr_remain (wr_remain),
        .chan_idle (chan_idle),
        .chan_done (chan_done)
    );

    task automatic chk(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic cycle();
        bit hs_src, hs_snk;
        #1;
        hs_src = src_valid && src_ready;
        hs_snk = snk_valid && snk_ready;
        if (snk_valid && !prev_valid && cfg_en)
            chk((pushed - popped) >= BURST, "R5", "words held at burst start", pushed - popped, BURST);
        if (!snk_valid && prev_valid && cfg_en)
            chk(burst_hs == BURST, "R5", "burst length", burst_hs, BURST);
        if (snk_valid && !prev_valid) burst_hs = 0;
        if (hs_snk) begin
            chk(snk_data == pop_word, "R4", "sink word order", snk_data, pop_word);
            pop_word++;
            popped++;
            burst_hs++;
        end
        prev_valid = snk_valid;
        @(posedge clk);
        if (hs_src) begin
            pushed++;
            next_word++;
        end
        #1;
        src_data = next_word;
        if (track) begin
            chk(rd_remain == CNT_W'(cnt - pushed), "R3", "read count", rd_remain, cnt - pushed);
            chk(wr_remain == CNT_W'(cnt - popped), "R6", "write count", wr_remain, cnt - popped);
        end
    endtask

    task automatic start(input int n);
        cfg_count = CNT_W'(n);
        cfg_en    = 1'b1;
        cnt       = n;
        pushed    = 0;
        popped    = 0;
        track     = 1'b0;
        cycle();
        track = 1'b1;
        chk(rd_remain == CNT_W'(n), "R2", "read count loaded", rd_remain, n);
        chk(wr_remain == CNT_W'(n), "R2", "write count loaded", wr_remain, n);
        chk(chan_idle == 1'b0, "R2", "idle cleared", chan_idle, 0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0; cfg_en = 1'b0; cfg_count = '0;
        src_valid = 1'b0; snk_ready = 1'b0;
        next_word = 16'h0100; pop_word = 16'h0100; src_data = next_word;
        track = 1'b0; prev_valid = 1'b0; burst_hs = 0;
        pushed = 0; popped = 0; cnt = 0;
        repeat (3) cycle();
        chk(chan_idle == 1'b1, "R1", "idle at reset", chan_idle, 1);
        chk(chan_done == 1'b0, "R1", "done at reset", chan_done, 0);
        chk(src_ready == 1'b0, "R1", "src_ready at reset", src_ready, 0);
        chk(snk_valid == 1'b0, "R1", "snk_valid at reset", snk_valid, 0);
        chk(rd_remain == '0, "R1", "read count at reset", rd_remain, 0);
        chk(wr_remain == '0, "R1", "write count at reset", wr_remain, 0);
        rst_n = 1'b1;
        cycle();
    endtask

    task automatic t_full_run();
        snk_ready = 1'b1;
        src_valid = 1'b1;
        start(12);
        for (int i = 0; i < 200 && !chan_done; i++) cycle();
        chk(chan_done == 1'b1, "R10", "done raised", chan_done, 1);
        chk(popped == 12, "R4", "words delivered", popped, 12);
        repeat (3) begin
            cycle();
            chk(chan_done == 1'b1, "R10", "done held while enabled", chan_done, 1);
            chk(src_ready == 1'b0, "R10", "no reads after done", src_ready, 0);
        end
        src_valid = 1'b0;
        cfg_en = 1'b0;
        cycle();
        chk(chan_idle == 1'b1, "R10", "idle after enable cleared", chan_idle, 1);
        chk(chan_done == 1'b0, "R10", "done cleared", chan_done, 0);
    endtask

    task automatic t_partial_flush();
        snk_ready = 1'b1;
        src_valid = 1'b0;
        start(10);
        src_valid = 1'b1;
        while (pushed < 3) cycle();
        src_valid = 1'b0;
        repeat (20) begin
            cycle();
            chk(snk_valid == 1'b0, "R5", "short tail held", snk_valid, 0);
        end
        chk(wr_remain == 16'd10, "R5", "write count unmoved", wr_remain, 10);
        cfg_en = 1'b0;
        for (int i = 0; i < 50 && !chan_idle; i++) cycle();
        chk(popped == 3, "R8", "tail flushed", popped, 3);
        chk(wr_remain == 16'd7, "R8", "write count after flush", wr_remain, 7);
        chk(chan_idle == 1'b1, "R9", "idle after flush", chan_idle, 1);
        src_valid = 1'b1;
        repeat (8) begin
            cycle();
            chk(src_ready == 1'b0, "R9", "no intake while idle", src_ready, 0);
        end
        chk(rd_remain == 16'd7, "R9", "read count frozen", rd_remain, 7);
        src_valid = 1'b0;
        cycle();
    endtask

    task automatic t_backpressure();
        snk_ready = 1'b0;
        src_valid = 1'b1;
        start(20);
        repeat (12) cycle();
        chk(src_ready == 1'b0, "R7", "stall when full", src_ready, 0);
        chk(pushed == DEPTH, "R7", "words held", pushed, DEPTH);
        chk(rd_remain == 16'd12, "R7", "read count at stall", rd_remain, 12);
        chk(wr_remain == 16'd20, "R6", "write count at stall", wr_remain, 20);
        snk_ready = 1'b1;
        for (int i = 0; i < 300 && !chan_done; i++) cycle();
        chk(chan_done == 1'b1, "R10", "done after backpressure", chan_done, 1);
        chk(popped == 20, "R4", "all words delivered", popped, 20);
        src_valid = 1'b0;
        cfg_en = 1'b0;
        cycle();
        chk(chan_idle == 1'b1, "R10", "idle after done", chan_idle, 1);
    endtask

    task automatic t_burst_plus_tail();
        snk_ready = 1'b1;
        src_valid = 1'b1;
        start(16);
        while (pushed < 6) cycle();
        src_valid = 1'b0;
        repeat (15) cycle();
        chk(popped == 4, "R5", "only full burst sent", popped, 4);
        chk(wr_remain == 16'd12, "R5", "write count after burst", wr_remain, 12);
        chk(rd_remain == 16'd10, "R3", "read count ahead", rd_remain, 10);
        cfg_en = 1'b0;
        for (int i = 0; i < 50 && !chan_idle; i++) cycle();
        chk(popped == 6, "R8", "tail of two flushed", popped, 6);
        chk(wr_remain == 16'd10, "R8", "write count after flush", wr_remain, 10);
        chk(rd_remain == wr_remain, "R6", "counts equal once drained", rd_remain, wr_remain);
        cycle();
    endtask

    bit finished = 1'b0;

    initial begin
        t_reset();
        t_full_run();
        t_partial_flush();
        t_backpressure();
        t_burst_plus_tail();
        finished = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog run did not complete actual=0 expected=1");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule